// File: doc/BRIEF.md
# Indexed Block-Transfer Serial Register Slave

This block is a two-wire serial bus slave that sits beside a clock fan-out stage. It gives a host read and write access to a seven-entry bank of byte-wide control registers. The serial clock and data lines are sampled in the system clock domain. The block drives the data line only through an open-drain pull-down enable. Some bits of the bank switch six differential output pairs on and off, and these bits are brought out as parallel enables.

Each write names a starting register and a byte count, then sends the data. The slave stores the data bytes in consecutive registers. A read first sets the starting register in a short write, then readdresses the slave with a repeated START. The slave answers with a count byte and then the register contents, moving to the next register after every byte for as long as the host acknowledges. Reserved bits cannot be changed by a write. A START or STOP at any point abandons the transfer in progress.

Top module: `idxblk_slave`

## Requirements
- R1: The slave acknowledges an address byte of D4h (7-bit address 6Ah, write) or D5h (same address, read). Any other address byte gets no acknowledge, and the slave then ignores the bus until the next START.
- R2: A write runs address D4h, start index N, count X, then data bytes. The first X data bytes go to registers N, N+1, and so on. Every byte is acknowledged. Data bytes after the first X are acknowledged and discarded.
- R3: After D4h and index N, a repeated START and D5h make the slave send a count byte of 07h (the number of registers), followed by the contents of registers N, N+1, and so on.
- R4: During a read the slave releases SDA in each acknowledge slot. After a host ACK (SDA low) it sends the next register. After a host NACK (SDA high) it keeps SDA released and returns to idle.
- R5: pair_en[0] is register 0 bit 7, pair_en[1] is register 0 bit 6, pair_en[2] is register 0 bit 3, pair_en[3] is register 1 bit 6, pair_en[4] is register 0 bit 0 and pair_en[5] is register 0 bit 2. A value of 1 enables the pair. The enables change only through a register write.
- R6: After reset, register 0 reads FFh, register 1 reads C0h, registers 2 to 6 read FFh, and all six pair enables are 1.
- R7: Reserved bits are read-only. These are bits 5, 4 and 1 of register 0, bits 7 and 5..0 of register 1, and all bits of registers 2 to 6. A write to them is acknowledged and leaves them unchanged.
- R8: The index advances after every data byte and wraps from 6 to 0. An index above 6 reads as FFh, ignores writes, and counts upward to 255 before wrapping.
- R9: A START or STOP at any point ends the current transfer and releases SDA. Registers written before the abort keep their new values. A START is then taken as a new address byte.
- R10: The slave changes its SDA drive only after SCL has fallen, never while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low |
| pair_en | output | 6 | Enable for each output pair, 1 = on |

## Verification
A wrong transfer phase shows at the ports within one bit time. It appears as a missing or misplaced acknowledge, or as SDA held low after a NACK or STOP. A corrupted index or count shows as a wrong byte in the first read that follows, or as a pair enable that changes when a different register was the target. Wrong masking or wrong reset values show in the first read-back of the bank and in pair_en as soon as reset is released.

// File: rtl/idxblk_pkg.sv
package idxblk_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RX_ACKW, S_RX_ACK, S_TX, S_TX_ACK, S_TX_NEXT
  } phase_t;

  typedef enum logic [1:0] {
    B_ADDR, B_INDEX, B_COUNT, B_DATA
  } role_t;

  // value each register takes at reset
  function automatic logic [7:0] reg_reset(input int i);
    return (i == 1) ? 8'hC0 : 8'hFF;
  endfunction

  // bits that a host write may change; all others are reserved
  function automatic logic [7:0] reg_wmask(input int i);
    case (i)
      0:       return 8'hCD;
      1:       return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/idxblk_sync.sv
module idxblk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/idxblk_regbank.sv
module idxblk_regbank
  import idxblk_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int PAIRS    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_idx,
  output logic [7:0]       rd_data,
  output logic [PAIRS-1:0] pair_en
);
  localparam int IW = $clog2(NUM_REGS);

  logic [7:0] bank [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RV = reg_reset(g);
    localparam logic [7:0] WM = reg_wmask(g);
    always_ff @(posedge clk) begin
      if (rst)
        bank[g] <= RV;
      else if (wr_en && wr_idx == 8'(g))
        bank[g] <= (bank[g] & ~WM) | (wr_data & WM);
    end
  end

  assign rd_data = (rd_idx < 8'(NUM_REGS)) ? bank[rd_idx[IW-1:0]] : 8'hFF;

  // pair enables sit at fixed positions in registers 0 and 1
  assign pair_en = {bank[0][2], bank[0][0], bank[1][6],
                    bank[0][3], bank[0][6], bank[0][7]};
endmodule

// File: rtl/idxblk_slave.sv
module idxblk_slave
  import idxblk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         NUM_REGS    = 7,
  parameter int         PAIRS       = 6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [PAIRS-1:0] pair_en
);
  localparam logic [7:0] LAST_IDX   = 8'(NUM_REGS - 1);
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  idxblk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_t     phase;
  role_t      role;
  logic [2:0] bitcnt;
  logic [6:0] rxsh;
  logic [7:0] txsh, idx, cnt;
  logic       do_ack, to_tx;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_data;
  logic [7:0] byte_in, idx_nx;

  assign byte_in = {rxsh, sda_s};
  assign idx_nx  = (idx == LAST_IDX) ? 8'h00 : idx + 8'h01;

  idxblk_regbank #(.NUM_REGS(NUM_REGS), .PAIRS(PAIRS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(idx), .rd_data(rd_data), .pair_en(pair_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= S_IDLE;
      role    <= B_ADDR;
      bitcnt  <= '0;
      rxsh    <= '0;
      txsh    <= '0;
      idx     <= '0;
      cnt     <= '0;
      do_ack  <= 1'b0;
      to_tx   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase  <= S_RX;
        role   <= B_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          S_RX: if (scl_rise) begin
            rxsh   <= byte_in[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              phase  <= S_RX_ACKW;
              do_ack <= 1'b1;
              to_tx  <= 1'b0;
              case (role)
                B_ADDR: begin
                  if (byte_in[7:1] == DEV_ADDR) begin
                    to_tx <= byte_in[0];
                    role  <= B_INDEX;
                  end else begin
                    do_ack <= 1'b0;
                  end
                end
                B_INDEX: begin
                  idx  <= byte_in;
                  role <= B_COUNT;
                end
                B_COUNT: begin
                  cnt  <= byte_in;
                  role <= B_DATA;
                end
                default: begin
                  if (cnt != 8'h00) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= idx;
                    wr_data <= byte_in;
                    idx     <= idx_nx;
                    cnt     <= cnt - 8'h01;
                  end
                end
              endcase
            end
          end
          S_RX_ACKW: if (scl_fall) begin
            if (do_ack) begin
              sda_oe <= 1'b1;
              phase  <= S_RX_ACK;
            end else begin
              phase  <= S_IDLE;
            end
          end
          S_RX_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (to_tx) begin
              txsh   <= COUNT_BYTE;
              sda_oe <= ~COUNT_BYTE[7];
              phase  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              phase  <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              phase  <= S_TX_ACK;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
          S_TX_ACK: if (scl_rise) begin
            if (!sda_s) begin
              txsh  <= rd_data;
              idx   <= idx_nx;
              phase <= S_TX_NEXT;
            end else begin
              phase <= S_IDLE;
            end
          end
          S_TX_NEXT: if (scl_fall) begin
            sda_oe <= ~txsh[7];
            bitcnt <= '0;
            phase  <= S_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idxblk_slave_chk.sv
module idxblk_slave_chk
  import idxblk_pkg::*;
#(
  parameter int PAIRS = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_fall,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             wr_en,
  input phase_t           phase,
  input logic [PAIRS-1:0] pair_en
);
  p_drive_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));

  p_release_after_stop_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  p_idle_released_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == S_IDLE) |-> !sda_oe);

  p_reset_pairs_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pair_en == {PAIRS{1'b1}}));

  p_pairs_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(pair_en));
endmodule

bind idxblk_slave idxblk_slave_chk #(.PAIRS(PAIRS)) u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .stop_det(stop_det),
  .sda_oe(sda_oe), .wr_en(wr_en), .phase(phase), .pair_en(pair_en)
);

// File: tb/idxblk_slave_tb.sv
module idxblk_slave_tb;
  localparam int Q  = 10;
  localparam int WD = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [5:0] pair_en;
  logic sda_line;

  assign sda_line = sda_h & ~sda_oe;

  always #5 clk = ~clk;

  idxblk_slave u_dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .pair_en(pair_en)
  );

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] model [7];
  logic [7:0] wq[$];
  int checks = 0, errors = 0, r10_bad = 0;
  logic oe_prev = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // R7 masks: writable bits per register
  function automatic logic [7:0] wmask(input int i);
    return (i == 0) ? 8'hCD : (i == 1) ? 8'h40 : 8'h00;
  endfunction
  function automatic logic [7:0] nxt(input logic [7:0] i);
    return (i == 8'd6) ? 8'd0 : i + 8'd1;
  endfunction
  function automatic logic [7:0] mread(input logic [7:0] i);
    return (i < 8'd7) ? model[i[2:0]] : 8'hFF;
  endfunction
  function automatic logic [5:0] exp_pairs();
    return {model[0][2], model[0][0], model[1][6], model[0][3], model[0][6], model[0][7]};
  endfunction

  // scoreboard monitor
  initial forever begin
    wait (got_q.size() > 0);
    begin
      logic [7:0] g;
      exp_t e;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      check(g === e.val, e.tag, g, e.val);
    end
  end

  // R10: SDA drive must not change while SCL is high
  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_prev && scl) r10_bad++;
    oe_prev = sda_oe;
  end

  task automatic qw(input int n);
    repeat (n * Q) @(negedge clk);
  endtask
  task automatic b_start();
    sda_h = 1'b1; qw(1); scl = 1'b1; qw(1); sda_h = 1'b0; qw(1); scl = 1'b0; qw(1);
  endtask
  task automatic b_stop();
    sda_h = 1'b0; qw(1); scl = 1'b1; qw(1); sda_h = 1'b1; qw(2);
  endtask
  task automatic wbit(input logic b);
    qw(1); sda_h = b; qw(1); scl = 1'b1; qw(2); scl = 1'b0;
  endtask
  task automatic rbit(output logic v);
    sda_h = 1'b1; qw(2); scl = 1'b1; qw(1); v = sda_line; qw(1); scl = 1'b0;
  endtask
  task automatic send(input logic [7:0] b, input logic want_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(a);
    check((!a) == want_ack, tag, !a, want_ack);
  endtask
  task automatic recv(input logic give_ack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) rbit(b[i]);
    got_q.push_back(b);
    wbit(!give_ack);
  endtask

  task automatic block_write(input logic [7:0] idx, input logic [7:0] cnt, input string tag);
    logic [7:0] i = idx;
    int left = cnt;
    b_start();
    send(8'hD4, 1'b1, "R1 write address ack");
    send(idx, 1'b1, {tag, " index ack"});
    send(cnt, 1'b1, {tag, " count ack"});
    foreach (wq[k]) begin
      send(wq[k], 1'b1, {tag, " data ack R2"});
      if (left > 0) begin
        if (i < 8'd7) model[i[2:0]] = (model[i[2:0]] & ~wmask(i)) | (wq[k] & wmask(i));
        i = nxt(i);
        left--;
      end
    end
    b_stop();
    wq.delete();
  endtask

  task automatic block_read(input logic [7:0] idx, input int n, input string tag);
    logic [7:0] i = idx;
    b_start();
    send(8'hD4, 1'b1, "R1 write address ack");
    send(idx, 1'b1, {tag, " index ack"});
    b_start();
    send(8'hD5, 1'b1, "R1 read address ack");
    exp_q.push_back('{8'h07, "R3 count byte"});
    recv(1'b1);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back('{mread(i), tag});
      i = nxt(i);
      recv(k < n - 1);
    end
    repeat (6) @(negedge clk);
    check(sda_oe == 1'b0, "R4 released after NACK", sda_oe, 0);
    b_stop();
  endtask

  task automatic run_tests();
    logic [7:0] r0v [6] = '{8'h80, 8'h40, 8'h08, 8'h00, 8'h01, 8'h04};
    logic [7:0] r1v [6] = '{8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 8'h00};
    model[0] = 8'hFF; model[1] = 8'hC0;
    for (int k = 2; k < 7; k++) model[k] = 8'hFF;
    check(pair_en == 6'h3F, "R6 reset pair_en", pair_en, 6'h3F);
    check(sda_oe == 1'b0, "R6 reset sda_oe", sda_oe, 0);
    block_read(8'd0, 7, "R6 reset value");

    // clear everything writable: reserved bits stay
    wq = '{8'h00, 8'h00};
    block_write(8'd0, 8'd2, "R7");
    check(pair_en == 6'h00, "R5 all pairs off", pair_en, 0);
    block_read(8'd0, 2, "R7 reserved kept");

    // one pair at a time
    for (int k = 0; k < 6; k++) begin
      wq = '{r0v[k], r1v[k]};
      block_write(8'd0, 8'd2, "R5");
      check(pair_en == 6'(1 << k), "R5 single pair map", pair_en, 1 << k);
    end

    // wrap from 6 to 0
    wq = '{8'hAA, 8'hBB, 8'hCC};
    block_write(8'd6, 8'd3, "R8 wrap write");
    check(pair_en == exp_pairs(), "R8 wrap pair_en", pair_en, exp_pairs());
    block_read(8'd5, 4, "R8 wrap read");

    // out-of-range index
    wq = '{8'h00};
    block_write(8'd9, 8'd1, "R8 high index");
    check(pair_en == exp_pairs(), "R8 high index ignored", pair_en, exp_pairs());
    block_read(8'd9, 2, "R8 high index read");

    // bytes past the count are discarded
    wq = '{8'h00, 8'hFF};
    block_write(8'd1, 8'd1, "R2 overrun");
    block_read(8'd0, 2, "R2 overrun read");

    // wrong addresses
    b_start();
    send(8'hA0, 1'b0, "R1 foreign address nack");
    send(8'h00, 1'b0, "R1 ignored until START");
    b_stop();
    b_start();
    send(8'hD6, 1'b0, "R1 neighbour address nack");
    b_stop();

    // STOP in the middle of a byte
    b_start();
    send(8'hD4, 1'b1, "R1 write address ack");
    send(8'h00, 1'b1, "R9 index ack");
    send(8'h03, 1'b1, "R9 count ack");
    send(8'h80, 1'b1, "R9 data ack");
    model[0] = (model[0] & ~8'hCD) | (8'h80 & 8'hCD);
    wbit(1'b0); wbit(1'b1); wbit(1'b0); wbit(1'b0);
    b_stop();
    check(pair_en == 6'h01, "R9 kept after STOP", pair_en, 1);

    // START in the middle of a byte, then read
    b_start();
    send(8'hD4, 1'b1, "R1 write address ack");
    send(8'h01, 1'b1, "R9 index ack");
    send(8'h01, 1'b1, "R9 count ack");
    wbit(1'b0); wbit(1'b1); wbit(1'b0);
    b_start();
    send(8'hD5, 1'b1, "R9 address after abort");
    exp_q.push_back('{8'h07, "R3 count byte"});
    recv(1'b1);
    exp_q.push_back('{model[1], "R9 aborted data dropped"});
    recv(1'b0);
    b_stop();
    check(pair_en == exp_pairs(), "R9 pairs after abort", pair_en, exp_pairs());
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    fork
      begin
        run_tests();
        wait (got_q.size() == 0);
        repeat (2) @(negedge clk);
      end
      begin
        repeat (WD) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    check(r10_bad == 0, "R10 drive changed with SCL high", r10_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule